// File: doc/BRIEF.md
# Synchronous ADC Serial Readback Receiver

This block sits on the host side of a sigma-delta converter that streams conversion results continuously. It runs from the master clock that also drives the converter. It watches the converter's data-ready strobe and generates a serial clock at half the master-clock rate. That serial clock is phase-locked to the strobe, so one 32-bit frame fills a whole output-data period. Each frame is a 24-bit signed result followed by an 8-bit status byte. The block presents the frame on parallel outputs together with a one-cycle valid pulse.

When `enable` rises, the block pulls chip select low and keeps it low for the whole session, because continuous readback needs no per-frame addressing. The first ready edge after that is used to fire a one-cycle sync pulse, which restarts the converter's filter. Every later ready edge starts a frame.

The block detects a lost frame in two ways: a ready edge that arrives before all 32 bits are in, or a final status bit that is not 1. In either case it discards the frame, raises a sticky error, and stops the serial clock until the next ready edge.

Top module: `adc_frame_rx`

## Requirements
- R1: During reset and after it, `cs_n` is 1, `sclk` is 1, and `valid`, `sync_out` and `frame_err` are 0.
- R2: `cs_n` goes low at the first clock edge that sees `enable` high, and stays low while `enable` stays high.
- R3: The first rising edge of `drdy` after enabling produces a `sync_out` pulse exactly one cycle long. It is visible after the third rising clock edge counted from the `drdy` change. This edge starts no frame and does not toggle `sclk`.
- R4: A later `drdy` rising edge drives `sclk` low at the third clock edge after the change. After that, `sclk` toggles on every edge, making exactly 32 rising edges, and it finishes high. A bit is sampled on each `sclk` rising edge.
- R5: The first 24 bits, MSB first, appear on `data_out` as a signed value, and the last 8 bits, MSB first, appear on `status_out`. `valid` is high for exactly one cycle, after the 66th rising clock edge counted from the `drdy` change. It is low one edge earlier.
- R6: `sclk` is high whenever no frame is in progress, including at the moment `drdy` rises.
- R7: If `drdy` rises while a frame is still being shifted in, that frame gives no `valid`, `frame_err` is set, and a new frame starts at bit 0 and is captured correctly.
- R8: If the last bit of a frame (bit 0 of the status byte) is 0, that frame gives no `valid` and `frame_err` is set. `sclk` stays high until the next `drdy` rising edge, and the next good frame is delivered. A serial clock edge that the converter misses is caught this way.
- R9: `frame_err` stays set until `err_clr` is high at a clock edge, which clears it.
- R10: While `enable` is low, `cs_n` is 1 at the next edge, `sclk` stays high and `drdy` edges produce no frames.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock, shared with the converter |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Starts and holds a readback session |
| err_clr | input | 1 | Clears the sticky framing error |
| drdy | input | 1 | Data-ready strobe from the converter (asynchronous) |
| sdo | input | 1 | Serial data from the converter |
| sclk | output | 1 | Serial clock, half the master-clock rate |
| cs_n | output | 1 | Active-low chip select |
| sync_out | output | 1 | One-cycle filter-restart pulse |
| data_out | output | 24 | Signed conversion result |
| status_out | output | 8 | Status byte of the frame |
| valid | output | 1 | One-cycle pulse marking a new result |
| frame_err | output | 1 | Sticky framing-error flag |

## Verification
The converter model in the bench reloads its frame and restarts at the MSB two edges after it raises `drdy`, and advances one bit on each falling `sclk` edge.

- **Timed frame.** One frame with idle time after it checks the latencies edge by edge, sampling 1 ns after each clock edge:
  - `sync_out` is high after edge 3 and low after edge 4.
  - `sclk` is still high after edge 2 and low after edge 3.
  - `valid` is low after edge 65 and high after edge 66.
- **Back-to-back frames.** These run with a period of 64 edges. A negative-edge monitor compares every `valid` against a queue of expected words, and any `valid` that arrives with an empty queue is a failure. This covers the frames that should be dropped and the sessions where the block is disabled.
- **Error cases.** The error flag and the `sclk` edge count are checked after each fault frame, once the following good frame has been delivered.

// File: rtl/adc_rx_pkg.sv
// Package: shared types for the ADC serial readback receiver.
// Assumes nothing beyond a single master-clock domain.
package adc_rx_pkg;
    // Session states of the readback controller.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ARM  = 2'd1,
        ST_RUN  = 2'd2
    } rx_state_t;
endpackage

// File: rtl/adc_rx_edge.sv
// Module: adc_rx_edge
// Brings the asynchronous ready strobe into the clock domain through a
// STAGES-deep flop chain and flags its rising edge for one cycle.
// Assumes the strobe stays high or low for at least two clock cycles.
module adc_rx_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise
);
    logic [STAGES:0] pipe;

    // Shift the strobe through the synchronizer plus one history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) pipe <= '0;
        else        pipe <= {pipe[STAGES-1:0], din};
    end

    assign rise = pipe[STAGES-1] & ~pipe[STAGES];
endmodule

// File: rtl/adc_rx_ctrl.sv
// Module: adc_rx_ctrl
// Session controller. It holds chip select low while enabled and spends
// the first ready edge on a one-cycle filter sync pulse. After that, every
// ready edge is passed on as a frame start.
// Assumes rise is a single-cycle pulse.
module adc_rx_ctrl
    import adc_rx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic rise,
    output logic cs_n,
    output logic sync_out,
    output logic run,
    output logic start
);
    rx_state_t state;

    // Advance the session state and produce the chip select and sync pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            cs_n     <= 1'b1;
            sync_out <= 1'b0;
        end else begin
            cs_n     <= ~enable;
            sync_out <= 1'b0;
            case (state)
                ST_IDLE: if (enable) state <= ST_ARM;
                ST_ARM: begin
                    if (!enable) state <= ST_IDLE;
                    else if (rise) begin
                        state    <= ST_RUN;
                        sync_out <= 1'b1;
                    end
                end
                ST_RUN:  if (!enable) state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign run   = (state == ST_RUN);
    assign start = run & rise;

    // R3: the sync pulse never lasts longer than one cycle.
    assert_sync_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sync_out |=> !sync_out);

    // R10: disabling the block releases chip select at the next edge.
    assert_cs_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> cs_n);
endmodule

// File: rtl/adc_rx_shift.sv
// Module: adc_rx_shift
// Serial clock generator and frame shifter. A start pulse drives sclk low
// (so the converter presents the MSB). sclk then toggles every clock, and a
// bit is sampled on each sclk rise. After FRAME_BITS samples the word is
// latched with a one-cycle done pulse and sclk rests high. A start that
// arrives mid-frame restarts at bit 0 and reports overrun.
// Assumes sdo changes only on falling sclk edges.
module adc_rx_shift #(
    parameter int FRAME_BITS = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  run,
    input  logic                  start,
    input  logic                  sdo,
    output logic                  sclk,
    output logic [FRAME_BITS-1:0] word,
    output logic                  done,
    output logic                  overrun
);
    localparam int CW = $clog2(FRAME_BITS);
    localparam logic [CW-1:0] LAST = CW'(FRAME_BITS - 1);

    logic                  busy;
    logic [CW-1:0]         cnt;
    logic [FRAME_BITS-1:0] shreg;

    // Generate sclk, count bits and shift in sampled data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            sclk    <= 1'b1;
            cnt     <= '0;
            shreg   <= '0;
            word    <= '0;
            done    <= 1'b0;
            overrun <= 1'b0;
        end else begin
            done    <= 1'b0;
            overrun <= 1'b0;
            if (!run) begin
                busy <= 1'b0;
                sclk <= 1'b1;
            end else if (start) begin
                overrun <= busy;
                busy    <= 1'b1;
                sclk    <= 1'b0;
                cnt     <= '0;
            end else if (busy) begin
                if (!sclk) begin
                    sclk  <= 1'b1;
                    shreg <= {shreg[FRAME_BITS-2:0], sdo};
                    cnt   <= cnt + 1'b1;
                    if (cnt == LAST) begin
                        busy <= 1'b0;
                        done <= 1'b1;
                        word <= {shreg[FRAME_BITS-2:0], sdo};
                    end
                end else begin
                    sclk <= 1'b0;
                end
            end
        end
    end

    // R4: a frame start is followed by a falling serial clock.
    assert_start_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !sclk);

    // R6: sclk rests high when a frame completes.
    assert_done_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> sclk);

    // R5: completions are at least two cycles apart.
    assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

// File: rtl/adc_frame_rx.sv
// Module: adc_frame_rx (top)
// Host-side receiver for a converter in continuous readback mode. It
// splits each frame into a signed result and a status byte, drops frames
// whose trailing marker bit is wrong or that were cut short, and holds a
// sticky error flag.
// Assumes the converter shares clk and holds its final status bit at 1.
module adc_frame_rx #(
    parameter int   DATA_W   = 24,
    parameter int   STAT_W   = 8,
    parameter int   STAGES   = 2,
    parameter logic MARK_VAL = 1'b1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     enable,
    input  logic                     err_clr,
    input  logic                     drdy,
    input  logic                     sdo,
    output logic                     sclk,
    output logic                     cs_n,
    output logic                     sync_out,
    output logic signed [DATA_W-1:0] data_out,
    output logic [STAT_W-1:0]        status_out,
    output logic                     valid,
    output logic                     frame_err
);
    localparam int FRAME_BITS = DATA_W + STAT_W;

    logic                  rise, run, start, done, overrun, bad_mark, new_err;
    logic [FRAME_BITS-1:0] word;

    adc_rx_edge #(.STAGES(STAGES)) u_edge (
        .clk(clk), .rst_n(rst_n), .din(drdy), .rise(rise)
    );

    adc_rx_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .enable(enable), .rise(rise),
        .cs_n(cs_n), .sync_out(sync_out), .run(run), .start(start)
    );

    adc_rx_shift #(.FRAME_BITS(FRAME_BITS)) u_shift (
        .clk(clk), .rst_n(rst_n), .run(run), .start(start), .sdo(sdo),
        .sclk(sclk), .word(word), .done(done), .overrun(overrun)
    );

    assign data_out   = word[FRAME_BITS-1:STAT_W];
    assign status_out = word[STAT_W-1:0];
    assign bad_mark   = (word[0] != MARK_VAL);
    assign valid      = done & ~bad_mark;
    assign new_err    = (done & bad_mark) | overrun;

    // Keep the framing error sticky; a new error wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)       frame_err <= 1'b0;
        else if (err_clr) frame_err <= new_err;
        else              frame_err <= frame_err | new_err;
    end

    // R9: the error flag only drops on a clear request.
    assert_err_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_err && !err_clr) |=> frame_err);

    // R8: a delivered result always carries the marker bit.
    assert_valid_mark_R8: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> (status_out[0] == MARK_VAL));
endmodule

// File: tb/adc_frame_rx_test.sv
module adc_frame_rx_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0, enable = 1'b0, err_clr = 1'b0, drdy = 1'b0, sdo = 1'b0;
    logic sclk, cs_n, sync_out, valid, frame_err;
    logic signed [23:0] data_out;
    logic [7:0] status_out;

    int checks = 0, failures = 0;
    logic [31:0] expq [0:63];
    int wr = 0, rd = 0;
    logic [31:0] cur = 32'h0;
    int idx = 32;
    bit drop_pending = 1'b0;
    int rises = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    adc_frame_rx uut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .err_clr(err_clr),
        .drdy(drdy), .sdo(sdo), .sclk(sclk), .cs_n(cs_n), .sync_out(sync_out),
        .data_out(data_out), .status_out(status_out), .valid(valid),
        .frame_err(frame_err)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Converter model: present the next bit on each falling sclk edge.
    always @(negedge sclk) begin
        if (drop_pending && idx == 10) drop_pending = 1'b0;
        else if (idx < 32) begin
            sdo = cur[31-idx];
            idx = idx + 1;
        end
    end

    always @(posedge sclk) rises++;

    // Compare every delivered result with the expected queue (R5, R7, R8, R10).
    always @(negedge clk) begin
        if (rst_n && valid) begin
            if (rd >= wr) chk(1'b0, "R5 unexpected valid", {data_out, status_out}, 32'h0);
            else begin
                chk({data_out, status_out} == expq[rd], "R5 frame data",
                    {data_out, status_out}, expq[rd]);
                rd++;
            end
        end
    end

    task automatic tick();
        @(posedge clk); #1;
    endtask

    // mode 0 plain, 1 latency checks, 2 sync checks. Starts/ends 1ns after an edge.
    task automatic frame(input logic [31:0] f, input int len, input int mode,
                         input bit drop);
        int r0;
        r0 = rises;
        drdy = 1'b1;
        for (int n = 1; n <= len; n++) begin
            @(posedge clk); #1;
            if (n == 2) begin cur = f; idx = 0; drop_pending = drop; end
            if (n == ((len > 40) ? 32 : len - 3)) drdy = 1'b0;
            if (mode == 2) begin
                if (n == 3) chk(sync_out == 1'b1, "R3 sync high at edge 3", 32'(sync_out), 1);
                if (n == 4) chk(sync_out == 1'b0, "R3 sync one cycle", 32'(sync_out), 0);
            end
            if (mode == 1) begin
                if (n == 2)  chk(sclk == 1'b1, "R6 sclk high at ready edge", 32'(sclk), 1);
                if (n == 3)  chk(sclk == 1'b0, "R4 sclk falls at edge 3", 32'(sclk), 0);
                if (n == 65) chk(valid == 1'b0, "R5 valid not early", 32'(valid), 0);
                if (n == 66) begin
                    chk(valid == 1'b1, "R5 valid at edge 66", 32'(valid), 1);
                    chk(data_out < 0, "R5 signed result", 32'(data_out), 32'(f[31:8]));
                end
                if (n == 67) chk(valid == 1'b0, "R5 valid one cycle", 32'(valid), 0);
            end
        end
        if (mode == 2) chk(rises == r0, "R3 no sclk on sync edge", rises - r0, 0);
        if (mode == 1) chk(rises - r0 == 32, "R4 32 sclk rises", rises - r0, 32);
    endtask

    function automatic logic [31:0] mk(input int i);
        logic [23:0] r;
        case (i)
            0: r = 24'h800000;
            1: r = 24'h7FFFFF;
            2: r = 24'h000000;
            3: r = 24'hFFFFFF;
            default: r = 24'(i * 24'h01F3A7 + 24'h00C5A1);
        endcase
        return {r, 7'(i), 1'b1};
    endfunction

    task automatic push(input logic [31:0] w);
        expq[wr] = w;
        wr++;
    endtask

    task automatic clear_err();
        err_clr = 1'b1; tick(); err_clr = 1'b0;
        chk(frame_err == 1'b0, "R9 clear", 32'(frame_err), 0);
    endtask

    initial begin
        int r0;
        repeat (4) tick();
        chk(cs_n == 1'b1 && sclk == 1'b1, "R1 reset cs_n/sclk", {cs_n, sclk}, 2'b11);
        chk(valid == 0 && sync_out == 0 && frame_err == 0, "R1 reset flags",
            {valid, sync_out, frame_err}, 0);
        rst_n = 1'b1; tick();
        chk(cs_n == 1'b1, "R1 idle after reset", 32'(cs_n), 1);
        enable = 1'b1; tick();
        chk(cs_n == 1'b0, "R2 cs_n low", 32'(cs_n), 0);
        chk(sclk == 1'b1, "R6 sclk idle high", 32'(sclk), 1);
        frame(32'h12345679, 64, 2, 1'b0);
        chk(rd == wr, "R3 no frame on sync edge", rd, wr);
        push(mk(0));
        frame(mk(0), 70, 1, 1'b0);
        for (int i = 1; i < 40; i++) begin
            push(mk(i));
            frame(mk(i), 64, 0, 1'b0);
        end
        repeat (4) tick();
        chk(rd == wr, "R5 all sweep frames delivered", rd, wr);
        chk(frame_err == 1'b0, "R7 no error in clean stream", 32'(frame_err), 0);
        chk(cs_n == 1'b0, "R2 cs_n held low", 32'(cs_n), 0);
        // R8 marker bit zero
        frame(32'hA5A5A5A4, 70, 0, 1'b0);
        chk(frame_err == 1'b1, "R8 bad marker sets error", 32'(frame_err), 1);
        chk(sclk == 1'b1, "R8 sclk halted high", 32'(sclk), 1);
        repeat (5) tick();
        chk(frame_err == 1'b1, "R9 error sticky", 32'(frame_err), 1);
        clear_err();
        push(mk(50));
        frame(mk(50), 70, 0, 1'b0);
        chk(rd == wr, "R8 recovery frame delivered", rd, wr);
        // R8 dropped serial clock edge
        frame(32'h3C3C3CFD, 70, 0, 1'b1);
        chk(frame_err == 1'b1, "R8 dropped edge detected", 32'(frame_err), 1);
        push(mk(51));
        frame(mk(51), 70, 0, 1'b0);
        chk(rd == wr, "R8 frame after drop", rd, wr);
        clear_err();
        // R7 ready edge mid-frame
        frame(mk(60), 20, 0, 1'b0);
        push(mk(61));
        frame(mk(61), 70, 0, 1'b0);
        chk(frame_err == 1'b1, "R7 mid-frame edge error", 32'(frame_err), 1);
        chk(rd == wr, "R7 restarted frame delivered", rd, wr);
        clear_err();
        // R10 disabled
        enable = 1'b0; tick();
        chk(cs_n == 1'b1, "R10 cs_n high", 32'(cs_n), 1);
        r0 = rises;
        frame(mk(70), 70, 0, 1'b0);
        chk(rises == r0, "R10 no sclk when disabled", rises - r0, 0);
        chk(sclk == 1'b1, "R10 sclk high", 32'(sclk), 1);
        chk(rd == wr, "R10 no frames when disabled", rd, wr);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule